// File: doc/BRIEF.md
# Trigger Pairing Handler

This block sits between the trigger distribution network and the user readout logic of a data-collecting front end. A timing pulse arrives on a dedicated input with precise timing, and some cycles later the matching trigger-information message arrives as a strobe carrying a type, a number, a code and an information word. The handler pairs the two and checks that they arrive in the right order. It reports each event with one of three pulses: timed-valid, valid without timing, or invalid. It holds the message fields for the user until the user releases them, and it keeps its own 16-bit count of timing pulses.

An event whose type has its top bit set never expects a timing pulse. Every other type must be preceded by a timing pulse that has not yet been matched. The user sees a data-valid level with stable fields and drops it with a release strobe that may last a single cycle. On that release, a 32-bit error pattern is captured. A message that is accepted while an earlier event is still unreleased waits in a one-entry pending slot. A timing pulse that gets no message within a programmable number of cycles is reported as invalid.

Top module: `trigger_pairing`

## Requirements
- R1: While reset is asserted and right after it, every output is zero.
- R2: The internal count `int_count_o` adds one in the cycle after each cycle in which `timing_pulse_i` is high, wraps at its width, and holds at all other times.
- R3: A timing pulse that arrives while no earlier pulse is waiting for its message raises `timed_ok_o` for one cycle, two cycles after the pulse.
- R4: A timing pulse that arrives while an earlier pulse is still waiting raises `invalid_o` one cycle later and gives no `timed_ok_o`. The new pulse replaces the old one as the waiting pulse.
- R5: A message whose type bit 3 is 0 that arrives while no pulse is waiting raises `invalid_o` one cycle later. It is discarded, so `data_valid_o` does not rise for it.
- R6: A message whose type bit 3 is 0 that arrives while a pulse is waiting is accepted and clears the waiting pulse. If nothing is held, `data_valid_o` rises one cycle later with the message's type, number, code and information on the outputs.
- R7: A message whose type bit 3 is 1 is accepted whatever the waiting state. One cycle after `data_valid_o` rises for such an event, `untimed_ok_o` pulses for one cycle.
- R8: While `data_valid_o` is high the four field outputs are stable. A `release_i` that is high for one cycle while `data_valid_o` is high clears `data_valid_o` in the next cycle and copies `err_pattern_i` to `err_captured_o`. A release while `data_valid_o` is low has no effect.
- R9: A message accepted while an event is held goes into a one-entry pending slot. After release, `data_valid_o` stays low for exactly one cycle and then rises with the pending fields. A further accepted message while the slot is full raises `invalid_o` one cycle later and is discarded.
- R10: `int_count_valid_o` rises five cycles after a timing pulse. It falls in the cycle after a release is accepted or after a new timing pulse, unless a rise is due in that same cycle.
- R11: If a pulse waits `TIMEOUT_CYCLES` cycles with no message of type bit 3 equal to 0, `invalid_o` pulses and the pulse stops waiting, so a later message of that kind is treated as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timing_pulse_i | input | 1 | One-cycle timing trigger pulse |
| info_strobe_i | input | 1 | Trigger-information message present |
| info_type_i | input | 4 | Message type; bit 3 set means no timing pulse is expected |
| info_number_i | input | 16 | Message trigger number |
| info_code_i | input | 8 | Message random code |
| info_detail_i | input | 24 | Message information word |
| release_i | input | 1 | User release of the held event |
| err_pattern_i | input | 32 | Error pattern, sampled on an accepted release |
| timed_ok_o | output | 1 | Valid timed trigger pulse |
| untimed_ok_o | output | 1 | Valid trigger without timing, pulse |
| invalid_o | output | 1 | Ordering error pulse |
| data_valid_o | output | 1 | Held fields are valid |
| trg_type_o | output | 4 | Held type |
| trg_number_o | output | 16 | Held trigger number |
| trg_code_o | output | 8 | Held code |
| trg_detail_o | output | 24 | Held information word |
| err_captured_o | output | 32 | Error pattern captured at the last accepted release |
| int_count_o | output | 16 | Internal timing pulse count |
| int_count_valid_o | output | 1 | Internal count is valid for the held event |

## Verification
Each result has a fixed lag from its stimulus:
- The count, `invalid_o` and `data_valid_o` are due one cycle after the input that causes them.
- `timed_ok_o` is due two cycles after its pulse.
- `untimed_ok_o` is due one cycle after the rise of `data_valid_o`.
- `int_count_valid_o` is due five cycles after the pulse.
- The timeout is due `TIMEOUT_CYCLES` cycles after the pulse.

The reference model advances on the same rising edge as the design and keeps each delayed result as a due-cycle number in a queue. Every output is compared in the following low clock phase. The directed checks wait exactly the number of cycles above before they sample.

// File: rtl/trigger_pairing_pkg.sv
package trigger_pairing_pkg;
  localparam int TYPE_W = 4;
  localparam int NUM_W  = 16;
  localparam int CODE_W = 8;
  localparam int INFO_W = 24;
  localparam int ERR_W  = 32;

  typedef struct packed {
    logic [TYPE_W-1:0] kind;
    logic [NUM_W-1:0]  num;
    logic [CODE_W-1:0] code;
    logic [INFO_W-1:0] info;
  } trig_fields_t;

  // top bit of the type marks an event that needs no timing pulse
  function automatic logic needs_timing(input logic [TYPE_W-1:0] k);
    return !k[TYPE_W-1];
  endfunction

  function automatic logic [NUM_W-1:0] count_step(input logic [NUM_W-1:0] c);
    return c + {{(NUM_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/tp_delay_line.sv
module tp_delay_line #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/tp_arm_tracker.sv
module tp_arm_tracker
  import trigger_pairing_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic             timed_msg_i,
  output logic             first_pulse_o,
  output logic             doubled_o,
  output logic             timeout_o,
  output logic             paired_o,
  output logic             orphan_o,
  output logic [NUM_W-1:0] count_o
);
  logic             armed;
  logic [TMO_W-1:0] tmo;
  logic             still_armed;

  assign timeout_o     = armed && (tmo == TMO_W'(TIMEOUT_CYCLES - 1)) && !timed_msg_i;
  assign still_armed   = armed && !timed_msg_i && !timeout_o;
  assign first_pulse_o = pulse_i && !still_armed;
  assign doubled_o     = pulse_i && still_armed;
  assign paired_o      = timed_msg_i && armed;
  assign orphan_o      = timed_msg_i && !armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      tmo     <= '0;
      count_o <= '0;
    end else begin
      armed <= pulse_i || still_armed;
      if (pulse_i)    tmo <= '0;
      else if (armed) tmo <= tmo + 1'b1;
      if (pulse_i) count_o <= count_step(count_o);
    end
  end
endmodule

// File: rtl/tp_event_presenter.sv
module tp_event_presenter
  import trigger_pairing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  trig_fields_t     fields_i,
  input  logic             release_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             valid_o,
  output trig_fields_t     held_o,
  output logic [ERR_W-1:0] err_o,
  output logic             untimed_ok_o,
  output logic             overflow_o,
  output logic             rel_taken_o
);
  trig_fields_t pend;
  logic         pend_v;
  logic         valid_d;

  assign rel_taken_o = release_i && valid_o;
  assign overflow_o  = accept_i && valid_o && pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o      <= 1'b0;
      valid_d      <= 1'b0;
      held_o       <= '0;
      pend         <= '0;
      pend_v       <= 1'b0;
      err_o        <= '0;
      untimed_ok_o <= 1'b0;
    end else begin
      valid_d      <= valid_o;
      untimed_ok_o <= valid_o && !valid_d && !needs_timing(held_o.kind);
      if (rel_taken_o) begin
        valid_o <= 1'b0;
        err_o   <= err_i;
      end else if (!valid_o && pend_v) begin
        held_o  <= pend;
        valid_o <= 1'b1;
      end
      if (!valid_o && !pend_v) begin
        if (accept_i) begin
          held_o  <= fields_i;
          valid_o <= 1'b1;
        end
      end else if (!valid_o) begin
        // pending entry moves out this cycle; a new message takes its place
        pend_v <= accept_i;
        if (accept_i) pend <= fields_i;
      end else if (!pend_v && accept_i) begin
        pend   <= fields_i;
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trigger_pairing.sv
module trigger_pairing
  import trigger_pairing_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int TIMED_LAG      = 2,
  parameter int COUNT_LAG      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timing_pulse_i,
  input  logic              info_strobe_i,
  input  logic [TYPE_W-1:0] info_type_i,
  input  logic [NUM_W-1:0]  info_number_i,
  input  logic [CODE_W-1:0] info_code_i,
  input  logic [INFO_W-1:0] info_detail_i,
  input  logic              release_i,
  input  logic [ERR_W-1:0]  err_pattern_i,
  output logic              timed_ok_o,
  output logic              untimed_ok_o,
  output logic              invalid_o,
  output logic              data_valid_o,
  output logic [TYPE_W-1:0] trg_type_o,
  output logic [NUM_W-1:0]  trg_number_o,
  output logic [CODE_W-1:0] trg_code_o,
  output logic [INFO_W-1:0] trg_detail_o,
  output logic [ERR_W-1:0]  err_captured_o,
  output logic [NUM_W-1:0]  int_count_o,
  output logic              int_count_valid_o
);
  localparam int CV_DEPTH = COUNT_LAG - 1;

  logic         timed_msg_w, untimed_msg_w, accept_w;
  logic         first_pulse_w, doubled_w, timeout_w, paired_w, orphan_w;
  logic         overflow_w, rel_taken_w, cv_rise_w;
  trig_fields_t in_fields, held;

  assign timed_msg_w   = info_strobe_i && needs_timing(info_type_i);
  assign untimed_msg_w = info_strobe_i && !needs_timing(info_type_i);
  assign accept_w      = paired_w || untimed_msg_w;
  assign in_fields     = '{kind: info_type_i, num: info_number_i,
                           code: info_code_i, info: info_detail_i};

  tp_arm_tracker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_arm (
    .clk(clk), .rst_n(rst_n), .pulse_i(timing_pulse_i), .timed_msg_i(timed_msg_w),
    .first_pulse_o(first_pulse_w), .doubled_o(doubled_w), .timeout_o(timeout_w),
    .paired_o(paired_w), .orphan_o(orphan_w), .count_o(int_count_o)
  );

  tp_event_presenter u_pres (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .fields_i(in_fields),
    .release_i(release_i), .err_i(err_pattern_i), .valid_o(data_valid_o),
    .held_o(held), .err_o(err_captured_o), .untimed_ok_o(untimed_ok_o),
    .overflow_o(overflow_w), .rel_taken_o(rel_taken_w)
  );

  tp_delay_line #(.DEPTH(TIMED_LAG)) u_timed_lag (
    .clk(clk), .rst_n(rst_n), .d(first_pulse_w), .q(timed_ok_o)
  );

  tp_delay_line #(.DEPTH(CV_DEPTH)) u_count_lag (
    .clk(clk), .rst_n(rst_n), .d(timing_pulse_i), .q(cv_rise_w)
  );

  assign trg_type_o   = held.kind;
  assign trg_number_o = held.num;
  assign trg_code_o   = held.code;
  assign trg_detail_o = held.info;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      invalid_o         <= 1'b0;
      int_count_valid_o <= 1'b0;
    end else begin
      invalid_o <= orphan_w || doubled_w || timeout_w || overflow_w;
      if (cv_rise_w)                         int_count_valid_o <= 1'b1;
      else if (rel_taken_w || timing_pulse_i) int_count_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/trigger_pairing_checker.sv
module trigger_pairing_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        timing_pulse_i,
  input logic        release_i,
  input logic        data_valid_o,
  input logic [3:0]  trg_type_o,
  input logic [15:0] trg_number_o,
  input logic [7:0]  trg_code_o,
  input logic [23:0] trg_detail_o,
  input logic        untimed_ok_o,
  input logic        timed_ok_o,
  input logic        invalid_o,
  input logic [15:0] int_count_o,
  input logic        doubled_w,
  input logic        timeout_w
);
  assert_fields_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid_o && $past(data_valid_o)) |-> ($stable(trg_type_o) && $stable(trg_number_o)
      && $stable(trg_code_o) && $stable(trg_detail_o)));

  assert_fall_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_valid_o) |-> $past(release_i));

  assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid_o && release_i) |=> !data_valid_o);

  assert_untimed_after_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    untimed_ok_o |-> ($past(data_valid_o) && !$past(data_valid_o, 2)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    timing_pulse_i |=> (int_count_o == 16'($past(int_count_o) + 16'd1)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !timing_pulse_i |=> $stable(int_count_o));

  assert_timed_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timed_ok_o |-> $past(timing_pulse_i, 2));

  assert_doubled_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    doubled_w |=> invalid_o);

  assert_timeout_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_w |=> invalid_o);
endmodule

bind trigger_pairing trigger_pairing_checker u_checker (
  .clk(clk), .rst_n(rst_n), .timing_pulse_i(timing_pulse_i), .release_i(release_i),
  .data_valid_o(data_valid_o), .trg_type_o(trg_type_o), .trg_number_o(trg_number_o),
  .trg_code_o(trg_code_o), .trg_detail_o(trg_detail_o), .untimed_ok_o(untimed_ok_o),
  .timed_ok_o(timed_ok_o), .invalid_o(invalid_o), .int_count_o(int_count_o),
  .doubled_w(doubled_w), .timeout_w(timeout_w)
);

// File: tb/trigger_pairing_bench.sv
`timescale 1ns/1ps
module trigger_pairing_bench;
  localparam int TMO = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        timing_pulse_i = 1'b0, info_strobe_i = 1'b0, release_i = 1'b0;
  logic [3:0]  info_type_i = '0;
  logic [15:0] info_number_i = '0;
  logic [7:0]  info_code_i = '0;
  logic [23:0] info_detail_i = '0;
  logic [31:0] err_pattern_i = '0;
  logic        timed_ok_o, untimed_ok_o, invalid_o, data_valid_o, int_count_valid_o;
  logic [3:0]  trg_type_o;
  logic [15:0] trg_number_o, int_count_o;
  logic [7:0]  trg_code_o;
  logic [23:0] trg_detail_o;
  logic [31:0] err_captured_o;

  trigger_pairing #(.TIMEOUT_CYCLES(TMO)) u_trigger_pairing (.*);

  int    vectors = 0, fails = 0, cyc = 0;
  string phase = "R1";
  bit    done = 0;

  // behavioural reference model
  typedef struct { logic [3:0] k; logic [15:0] n; logic [7:0] c; logic [23:0] d; } ev_t;
  ev_t         m_cur, m_pend, m_new;
  bit          m_armed, m_dv, m_dv_prev, m_pv, m_inv, m_uok, m_tok, m_cv;
  int          m_tmo;
  logic [15:0] m_cnt;
  logic [31:0] m_err;
  int          okq[$], cvq[$];
  bit          t_msg, u_msg, tmo_now, arm_eff, acc, inv, rel_acc, cv_rise, dv0, pv0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cur = '{0, 0, 0, 0}; m_pend = '{0, 0, 0, 0};
      m_armed = 0; m_dv = 0; m_dv_prev = 0; m_pv = 0; m_inv = 0; m_uok = 0;
      m_tok = 0; m_cv = 0; m_tmo = 0; m_cnt = 0; m_err = 0;
      okq.delete(); cvq.delete();
    end else begin
      t_msg   = info_strobe_i && !info_type_i[3];
      u_msg   = info_strobe_i && info_type_i[3];
      tmo_now = m_armed && (m_tmo == TMO - 1) && !t_msg;
      arm_eff = m_armed && !t_msg && !tmo_now;
      acc     = u_msg || (t_msg && m_armed);
      inv     = (t_msg && !m_armed) || tmo_now || (timing_pulse_i && arm_eff)
                || (acc && m_dv && m_pv);
      rel_acc = release_i && m_dv;
      m_tok = 0;
      if (okq.size() > 0 && okq[0] == cyc) begin m_tok = 1; void'(okq.pop_front()); end
      cv_rise = 0;
      if (cvq.size() > 0 && cvq[0] == cyc) begin cv_rise = 1; void'(cvq.pop_front()); end
      if (timing_pulse_i && !arm_eff) okq.push_back(cyc + 1);
      if (timing_pulse_i) begin cvq.push_back(cyc + 4); m_cnt = m_cnt + 16'd1; end
      m_inv = inv;
      m_uok = m_dv && !m_dv_prev && m_cur.k[3];
      m_dv_prev = m_dv;
      if (cv_rise) m_cv = 1; else if (rel_acc || timing_pulse_i) m_cv = 0;
      if (timing_pulse_i) m_tmo = 0; else if (m_armed) m_tmo = m_tmo + 1;
      m_armed = timing_pulse_i || arm_eff;
      m_new = '{info_type_i, info_number_i, info_code_i, info_detail_i};
      dv0 = m_dv; pv0 = m_pv;
      if (rel_acc) begin m_dv = 0; m_err = err_pattern_i; end
      else if (!dv0 && pv0) begin m_cur = m_pend; m_dv = 1; end
      if (acc && !dv0 && !pv0) begin m_cur = m_new; m_dv = 1; end
      else if (acc && !(dv0 && pv0)) begin m_pend = m_new; m_pv = 1; end
      else if (!dv0 && pv0) m_pv = 0;
    end
  end

  task automatic cmp(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R2", "int_count", 32'(int_count_o), 32'(m_cnt));
      cmp("R3", "timed_ok", 32'(timed_ok_o), 32'(m_tok));
      cmp(phase, "invalid", 32'(invalid_o), 32'(m_inv));
      cmp(phase, "data_valid", 32'(data_valid_o), 32'(m_dv));
      cmp("R7", "untimed_ok", 32'(untimed_ok_o), 32'(m_uok));
      cmp("R10", "count_valid", 32'(int_count_valid_o), 32'(m_cv));
      cmp("R8", "err_captured", err_captured_o, m_err);
      if (m_dv) begin
        cmp("R8", "type", 32'(trg_type_o), 32'(m_cur.k));
        cmp("R8", "number", 32'(trg_number_o), 32'(m_cur.n));
        cmp("R8", "code", 32'(trg_code_o), 32'(m_cur.c));
        cmp("R8", "detail", 32'(trg_detail_o), 32'(m_cur.d));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog R1 actual running expected finished");
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    timing_pulse_i = 1; tick(1); timing_pulse_i = 0;
  endtask

  task automatic send(input logic [3:0] k, input logic [15:0] n, input logic [7:0] c,
                      input logic [23:0] d);
    info_strobe_i = 1; info_type_i = k; info_number_i = n; info_code_i = c; info_detail_i = d;
    tick(1); info_strobe_i = 0;
  endtask

  task automatic rel(input logic [31:0] e);
    release_i = 1; err_pattern_i = e; tick(1); release_i = 0; err_pattern_i = '0;
  endtask

  initial begin
    // R1: reset state
    tick(3);
    cmp("R1", "reset data_valid", 32'(data_valid_o), 0);
    cmp("R1", "reset count", 32'(int_count_o), 0);
    cmp("R1", "reset invalid", 32'(invalid_o), 0);
    rst_n = 1;
    tick(2);
    cmp("R1", "post-reset err", err_captured_o, 0);

    phase = "R6";
    pulse();
    cmp("R2", "count after pulse", 32'(int_count_o), 1);
    tick(1);
    cmp("R3", "timed_ok two cycles after", 32'(timed_ok_o), 1);
    tick(2);
    send(4'h1, 16'h1234, 8'h5A, 24'hABCDEF);
    cmp("R6", "data_valid up", 32'(data_valid_o), 1);
    cmp("R6", "number", 32'(trg_number_o), 32'h1234);
    cmp("R10", "count valid at five", 32'(int_count_valid_o), 1);
    tick(3);
    rel(32'hA5A5_0001);
    cmp("R8", "dv down after release", 32'(data_valid_o), 0);
    cmp("R8", "err captured", err_captured_o, 32'hA5A5_0001);
    cmp("R10", "count valid down", 32'(int_count_valid_o), 0);
    tick(3);

    phase = "R4";
    pulse(); pulse();
    cmp("R4", "double pulse invalid", 32'(invalid_o), 1);
    tick(1);
    send(4'h2, 16'h0002, 8'h11, 24'h000022);
    rel(32'h0000_0002);
    tick(6);

    phase = "R5";
    send(4'h3, 16'h0BAD, 8'h00, 24'h0);
    cmp("R5", "orphan invalid", 32'(invalid_o), 1);
    cmp("R5", "orphan discarded", 32'(data_valid_o), 0);
    tick(2);

    phase = "R7";
    send(4'h9, 16'h0777, 8'h77, 24'h777777);
    tick(1);
    cmp("R7", "untimed ok", 32'(untimed_ok_o), 1);
    rel(32'h0000_0007);
    tick(2);

    phase = "R9";
    pulse(); tick(2);
    send(4'h1, 16'h0A0A, 8'h0A, 24'h0A0A0A);
    send(4'h9, 16'h0B0B, 8'h0B, 24'h0B0B0B);
    send(4'hA, 16'h0C0C, 8'h0C, 24'h0C0C0C);
    cmp("R9", "overflow invalid", 32'(invalid_o), 1);
    rel(32'h0000_0009);
    cmp("R9", "gap cycle", 32'(data_valid_o), 0);
    tick(1);
    cmp("R9", "pending shown", 32'(trg_number_o), 32'h0B0B);
    tick(2);
    rel(32'h0000_000B);
    tick(2);

    phase = "R8";
    rel(32'hFFFF_FFFF);
    cmp("R8", "release ignored while low", err_captured_o, 32'h0000_000B);
    tick(2);

    phase = "R11";
    pulse();
    tick(TMO);
    cmp("R11", "timeout invalid", 32'(invalid_o), 1);
    tick(2);
    send(4'h4, 16'h0404, 8'h04, 24'h040404);
    cmp("R11", "disarmed after timeout", 32'(invalid_o), 1);
    tick(4);
    finish_run();
  end
endmodule